// File: doc/BRIEF.md
# Real-Time Clock Command and Shift Interface

This block is the host-facing control path of a real-time clock. A host selects an operation with a 3-bit parallel code and confirms it with a strobe. One parallel code, all ones, is an escape. It hands the choice to a 4-bit command field that the host loads serially through the same serial clock and data pin that carry time data. The block holds a time shift register. With a parallel command the register runs 40 bits wide and has no year field. With the escape it runs 48 bits wide and includes the year, and it is then chained to the 4-bit command field for 52 shift positions.

Four operations exist: hold, shift, time set and time read. A time set copies the shift register into the external time counter. It then freezes the counter and resets the upper prescaler stages, so that a later release starts the new time on a fresh 1/64 s boundary. A time read copies the counter into the shift register. After either transfer the data register ignores serial clocks until the host issues a shift command. A single output pin shows either the 1 Hz tick or the register's least significant bit, depending on the operation.

All inputs are sampled by the system clock. The strobe and the serial clock act on their rising edges as seen in that clock domain. The data paths are a serial bit stream and a single-word transfer to and from the counter, and neither can stall. For that reason they use plain pins with no valid/ready handshake.

Top module: `rtc_cmd_shift_if`

## Requirements
- R1: After reset the operation is hold. `dout` follows `tick_1hz`, and `cnt_hold`, `cnt_load`, `cnt_capture` and `div_rst` are low.
- R2: On a strobe rising edge, a parallel code of 0, 1, 2 or 3 selects hold, shift, time set or time read. The code 3'b111 instead takes the operation from the 4-bit command field, with the same values 0 to 3. The command field's bit 0 is the earliest of the last four bits shifted in.
- R3: In hold, serial clocks leave the data register unchanged, and `dout` follows `tick_1hz`.
- R4: In shift, each serial clock rising edge moves the data register one place toward bit 0, and `dout` shows bit 0. With a parallel code present, `sdin` enters at bit 39. With 3'b111 present, `sdin` enters command-field bit 3, and command-field bit 0 enters data bit 47.
- R5: While `cmd_code` is 3'b111, the command field shifts on every serial clock in any operation. With any other code it never shifts.
- R6: A time set raises `cnt_load` for exactly one cycle, in the cycle after the strobe edge is seen. `cnt_ld_data` carries the register: all 48 bits with 3'b111, otherwise bits 39:0 with bits 47:40 at zero. `cnt_ld_wide` is high only with 3'b111. `dout` shows data bit 0.
- R7: A time set raises `cnt_hold` and gives a one-cycle `div_rst` pulse alongside `cnt_load`. `cnt_hold` stays high until a hold, shift or read command.
- R8: A time read gives a one-cycle `cnt_capture` pulse and loads `cnt_rd_data` into the register: 48 bits with 3'b111, otherwise bits 39:0 only. `dout` then follows `tick_1hz`.
- R9: After a time set or time read, serial clocks leave the data register unchanged until a shift command.
- R10: Parallel codes 4, 5 and 6, and command-field values 4 to 15, change nothing: no operation change and no pulse.
- R11: If a strobe edge and a serial clock edge are seen in the same cycle, the strobe is taken and that serial clock edge is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_code | input | 3 | Parallel command code; 3'b111 escapes to the command field |
| cmd_stb | input | 1 | Command strobe, acts on its rising edge |
| sclk | input | 1 | Serial shift clock, acts on its rising edge |
| sdin | input | 1 | Serial data in |
| tick_1hz | input | 1 | 1 Hz square wave shown on `dout` in hold and read |
| cnt_rd_data | input | 48 | Present value of the time counter |
| dout | output | 1 | Serial data out or 1 Hz tick |
| cnt_load | output | 1 | One-cycle pulse: load `cnt_ld_data` into the counter |
| cnt_ld_data | output | 48 | Time value for the counter load |
| cnt_ld_wide | output | 1 | Load includes the year field |
| cnt_capture | output | 1 | One-cycle pulse marking a counter read |
| cnt_hold | output | 1 | Counter frozen after a time set |
| div_rst | output | 1 | One-cycle pulse that resets the upper prescaler stages |

## Verification
The assertions assume that `cmd_stb` and `sclk` are synchronous to `clk`, and that each of their levels lasts at least one clock. They also assume that `cmd_code` is settled when a strobe edge arrives and that `cnt_rd_data` is stable at that edge. The stimulus changes all inputs on the falling clock edge and holds every strobe and serial clock level for two clocks. It changes `cmd_code` only together with a strobe or before a serial command load. Same-cycle strobe and serial clock edges are produced on purpose only once, to check the priority rule.

// File: rtl/rtc_if_pkg.sv
package rtc_if_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD  = 2'd0,
    MODE_SHIFT = 2'd1,
    MODE_SET   = 2'd2,
    MODE_READ  = 2'd3
  } rtc_mode_e;
endpackage

// File: rtl/rtc_rise_det.sv
module rtc_rise_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  output logic rise
);
  logic sig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_q <= 1'b0;
    else        sig_q <= sig;
  end

  assign rise = sig & ~sig_q;
endmodule

// File: rtl/rtc_cmd_decode.sv
module rtc_cmd_decode
  import rtc_if_pkg::*;
#(
  parameter int CODE_W = 3,
  parameter int CMDF_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb_rise,
  input  logic [CODE_W-1:0] code,
  input  logic [CMDF_W-1:0] cmd_field,
  output rtc_mode_e         mode,
  output logic              set_now,
  output logic              read_now,
  output logic              cnt_load,
  output logic              cnt_capture,
  output logic              cnt_hold,
  output logic              div_rst
);
  localparam logic [CODE_W-1:0] ESC_CODE = '1;
  localparam logic [CMDF_W-1:0] N_OPS    = CMDF_W'(4);

  logic [CMDF_W-1:0] eff;
  logic              valid;
  rtc_mode_e         new_mode;

  always_comb begin
    if (code == ESC_CODE) eff = cmd_field;
    else                  eff = CMDF_W'(code);
    valid    = stb_rise && (eff < N_OPS);
    new_mode = rtc_mode_e'(eff[1:0]);
    set_now  = valid && (new_mode == MODE_SET);
    read_now = valid && (new_mode == MODE_READ);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode        <= MODE_HOLD;
      cnt_load    <= 1'b0;
      cnt_capture <= 1'b0;
      div_rst     <= 1'b0;
      cnt_hold    <= 1'b0;
    end else begin
      cnt_load    <= set_now;
      div_rst     <= set_now;
      cnt_capture <= read_now;
      if (valid) begin
        mode     <= new_mode;
        cnt_hold <= (new_mode == MODE_SET);
      end
    end
  end

  a_r6_load_single: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_load |=> !cnt_load);
  a_r7_hold_with_load: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_load |-> cnt_hold);
  a_r7_released: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MODE_SET) |-> !cnt_hold);
  a_r8_pulses_apart: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cnt_load, cnt_capture}));
  a_r10_ignored_code: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_rise && !valid) |=> $stable(mode));
endmodule

// File: rtl/rtc_shift_chain.sv
module rtc_shift_chain
  import rtc_if_pkg::*;
#(
  parameter int WIDE_W   = 48,
  parameter int NARROW_W = 40,
  parameter int CMDF_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_rise,
  input  logic              ser,
  input  rtc_mode_e         mode,
  input  logic              set_now,
  input  logic              read_now,
  input  logic              sdin,
  input  logic [WIDE_W-1:0] cnt_rd_data,
  output logic [CMDF_W-1:0] cmd_field,
  output logic              data_lsb,
  output logic [WIDE_W-1:0] ld_data,
  output logic              ld_wide
);
  localparam logic [WIDE_W-1:0] NMASK = WIDE_W'({NARROW_W{1'b1}});

  logic [WIDE_W-1:0] sr, sr_n;
  logic [CMDF_W-1:0] cr, cr_n;

  always_comb begin
    sr_n = sr;
    cr_n = cr;
    if (read_now) begin
      if (ser) sr_n = cnt_rd_data;
      else     sr_n = (sr & ~NMASK) | (cnt_rd_data & NMASK);
    end else if (shift_rise) begin
      if (ser) begin
        cr_n = {sdin, cr[CMDF_W-1:1]};
        if (mode == MODE_SHIFT) sr_n = {cr[0], sr[WIDE_W-1:1]};
      end else if (mode == MODE_SHIFT) begin
        sr_n[NARROW_W-1:0] = {sdin, sr[NARROW_W-1:1]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr      <= '0;
      cr      <= '0;
      ld_data <= '0;
      ld_wide <= 1'b0;
    end else begin
      sr <= sr_n;
      cr <= cr_n;
      if (set_now) begin
        ld_data <= ser ? sr : (sr & NMASK);
        ld_wide <= ser;
      end
    end
  end

  assign cmd_field = cr;
  assign data_lsb  = sr[0];

  a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MODE_SHIFT && !read_now) |=> $stable(sr));
  a_r5_field_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !ser |=> $stable(cr));
  a_r5_field_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (ser && shift_rise && !read_now) |=> (cr[CMDF_W-1] == $past(sdin)));
  a_r6_narrow_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (set_now && !ser) |=> ((ld_data & ~NMASK) == '0));
endmodule

// File: rtl/rtc_cmd_shift_if.sv
module rtc_cmd_shift_if
  import rtc_if_pkg::*;
#(
  parameter int WIDE_W   = 48,
  parameter int NARROW_W = 40,
  parameter int CMDF_W   = 4,
  parameter int CODE_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] cmd_code,
  input  logic              cmd_stb,
  input  logic              sclk,
  input  logic              sdin,
  input  logic              tick_1hz,
  input  logic [WIDE_W-1:0] cnt_rd_data,
  output logic              dout,
  output logic              cnt_load,
  output logic [WIDE_W-1:0] cnt_ld_data,
  output logic              cnt_ld_wide,
  output logic              cnt_capture,
  output logic              cnt_hold,
  output logic              div_rst
);
  localparam int N_EDGE = 2;
  localparam logic [CODE_W-1:0] ESC_CODE = '1;

  logic [N_EDGE-1:0] raw, rises;
  logic              stb_rise, shift_rise, ser, set_now, read_now, data_lsb;
  logic [CMDF_W-1:0] cmd_field;
  rtc_mode_e         mode;

  assign raw = {sclk, cmd_stb};

  for (genvar g = 0; g < N_EDGE; g++) begin : g_edge
    rtc_rise_det u_det (
      .clk  (clk),
      .rst_n(rst_n),
      .sig  (raw[g]),
      .rise (rises[g])
    );
  end

  assign stb_rise   = rises[0];
  assign shift_rise = rises[1] & ~rises[0];
  assign ser        = (cmd_code == ESC_CODE);

  rtc_cmd_decode #(.CODE_W(CODE_W), .CMDF_W(CMDF_W)) u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .stb_rise   (stb_rise),
    .code       (cmd_code),
    .cmd_field  (cmd_field),
    .mode       (mode),
    .set_now    (set_now),
    .read_now   (read_now),
    .cnt_load   (cnt_load),
    .cnt_capture(cnt_capture),
    .cnt_hold   (cnt_hold),
    .div_rst    (div_rst)
  );

  rtc_shift_chain #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W), .CMDF_W(CMDF_W)) u_chain (
    .clk        (clk),
    .rst_n      (rst_n),
    .shift_rise (shift_rise),
    .ser        (ser),
    .mode       (mode),
    .set_now    (set_now),
    .read_now   (read_now),
    .sdin       (sdin),
    .cnt_rd_data(cnt_rd_data),
    .cmd_field  (cmd_field),
    .data_lsb   (data_lsb),
    .ld_data    (cnt_ld_data),
    .ld_wide    (cnt_ld_wide)
  );

  always_comb begin
    unique case (mode)
      MODE_SHIFT, MODE_SET: dout = data_lsb;
      default:              dout = tick_1hz;
    endcase
  end

  a_r7_div_with_load: assert property (@(posedge clk) disable iff (!rst_n)
    div_rst |-> cnt_load);
endmodule

// File: tb/rtc_cmd_shift_if_bench.sv
module rtc_cmd_shift_if_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cmd_code = 3'd0;
  logic        cmd_stb = 1'b0, sclk = 1'b0, sdin = 1'b0, tick_1hz = 1'b0;
  logic [47:0] cnt_rd_data = '0;
  logic        dout, cnt_load, cnt_ld_wide, cnt_capture, cnt_hold, div_rst;
  logic [47:0] cnt_ld_data;

  int n_chk = 0, n_bad = 0, n_ld = 0, n_cap = 0, n_div = 0;
  logic [47:0] ld_seen = '0;
  logic        ld_w_seen = 1'b0;
  bit          done = 1'b0;

  localparam logic [47:0] MASK40 = 48'h00FF_FFFF_FFFF;

  always #2.5 clk = ~clk;

  rtc_cmd_shift_if u_rtc_cmd_shift_if (
    .clk(clk), .rst_n(rst_n), .cmd_code(cmd_code), .cmd_stb(cmd_stb),
    .sclk(sclk), .sdin(sdin), .tick_1hz(tick_1hz), .cnt_rd_data(cnt_rd_data),
    .dout(dout), .cnt_load(cnt_load), .cnt_ld_data(cnt_ld_data),
    .cnt_ld_wide(cnt_ld_wide), .cnt_capture(cnt_capture),
    .cnt_hold(cnt_hold), .div_rst(div_rst)
  );

  always @(posedge clk) begin
    if (rst_n) begin
      if (cnt_load) begin n_ld++; ld_seen <= cnt_ld_data; ld_w_seen <= cnt_ld_wide; end
      if (cnt_capture) n_cap++;
      if (div_rst) n_div++;
    end
  end

  task automatic ceq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(input logic [2:0] c);
    @(negedge clk); cmd_code = c; cmd_stb = 1'b1;
    wait_n(2); cmd_stb = 1'b0; wait_n(2);
  endtask

  task automatic pulse(input logic b);
    @(negedge clk); sdin = b; sclk = 1'b1;
    wait_n(2); sclk = 1'b0; wait_n(2);
  endtask

  task automatic shift_in(input logic [47:0] v, input int n);
    for (int i = 0; i < n; i++) pulse(v[i]);
  endtask

  task automatic shift_out(input int n, output logic [47:0] v);
    v = '0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); v[i] = dout;
      pulse(1'b0);
    end
  endtask

  task automatic ser_cmd(input logic [3:0] c);
    @(negedge clk); cmd_code = 3'b111;
    for (int i = 0; i < 4; i++) pulse(c[i]);
  endtask

  task automatic run_case(input bit wide, input int k);
    logic [47:0] p, q, m, got;
    int w, ld0, cap0, div0;
    p = {16'(k * 16'h9E37 + 16'h1234), 32'(k * 32'h6C8E_9CF5) ^ 32'hA5A5_0F0F};
    q = {16'(k * 16'h3B1D + 16'h0F0F), 32'(k * 32'h2545_F491) ^ 32'h5A3C_96E1};
    m = wide ? 48'hFFFF_FFFF_FFFF : MASK40;
    w = wide ? 48 : 40;
    ld0 = n_ld; div0 = n_div;
    if (wide) begin
      @(negedge clk); cmd_code = 3'b111;
      shift_in(p, 48);
      shift_in(48'h2, 4);
      strobe(3'b111);
    end else begin
      shift_in(p, 40);
      strobe(3'd2);
    end
    ceq("R6 one load pulse", 64'(n_ld - ld0), 64'd1);
    ceq("R6 load data", 64'(ld_seen), 64'(p & m));
    ceq("R6 load wide flag", 64'(ld_w_seen), 64'(wide));
    ceq("R6 dout shows lsb in set", 64'(dout), 64'(p[0]));
    ceq("R7 counter held", 64'(cnt_hold), 64'd1);
    ceq("R7 divider reset pulse", 64'(n_div - div0), 64'd1);
    if (wide) ser_cmd(4'h1);
    else for (int i = 0; i < 6; i++) pulse(1'b1);
    ceq("R9 frozen after set", 64'(dout), 64'(p[0]));
    strobe(wide ? 3'b111 : 3'd1);
    ceq("R7 hold released", 64'(cnt_hold), 64'd0);
    shift_out(w, got);
    ceq(wide ? "R4 R5 R9 wide readout" : "R4 R9 narrow readout", 64'(got), 64'(p & m));
    cap0 = n_cap;
    cnt_rd_data = q;
    if (wide) begin ser_cmd(4'h3); strobe(3'b111); end
    else strobe(3'd3);
    cnt_rd_data = ~q;
    ceq("R8 one capture pulse", 64'(n_cap - cap0), 64'd1);
    @(negedge clk); tick_1hz = 1'b1; @(negedge clk);
    ceq("R8 dout tick high", 64'(dout), 64'd1);
    tick_1hz = 1'b0; @(negedge clk);
    ceq("R8 dout tick low", 64'(dout), 64'd0);
    if (wide) ser_cmd(4'h1);
    else for (int i = 0; i < 3; i++) pulse(1'b1);
    strobe(wide ? 3'b111 : 3'd1);
    shift_out(w, got);
    ceq("R8 R9 read value", 64'(got), 64'(q & m));
  endtask

  initial begin
    logic [47:0] p, got;
    int ld0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);
    tick_1hz = 1'b1; @(negedge clk);
    ceq("R1 dout follows tick", 64'(dout), 64'd1);
    tick_1hz = 1'b0; @(negedge clk);
    ceq("R1 dout follows tick low", 64'(dout), 64'd0);
    ceq("R1 outputs idle", 64'({cnt_hold, cnt_load, cnt_capture, div_rst}), 64'd0);
    strobe(3'd1);
    for (int k = 0; k < 6; k++) begin
      run_case(1'b0, k);
      @(negedge clk); cmd_code = 3'b111;
      shift_in(48'h0, 48); shift_in(48'h0, 4);
      run_case(1'b1, k);
      strobe(3'd1);
    end
    // R2 R3 R10 R11: hold, ignored codes, same-cycle edges
    p = 48'h00C3_5A96_0F1E;
    ld0 = n_ld;
    shift_in(p, 40);
    @(negedge clk); cmd_code = 3'd0; cmd_stb = 1'b1; sdin = 1'b1; sclk = 1'b1;
    wait_n(2); cmd_stb = 1'b0; sclk = 1'b0; wait_n(2);
    for (int i = 0; i < 5; i++) pulse(1'b1);
    tick_1hz = 1'b1; @(negedge clk);
    ceq("R3 hold dout tick", 64'(dout), 64'd1);
    strobe(3'd5);
    tick_1hz = 1'b0; @(negedge clk);
    ceq("R10 code 5 ignored", 64'(dout), 64'd0);
    ser_cmd(4'h9);
    strobe(3'b111);
    tick_1hz = 1'b1; @(negedge clk);
    ceq("R10 field 9 ignored", 64'(dout), 64'd1);
    ceq("R10 no load pulse", 64'(n_ld - ld0), 64'd0);
    tick_1hz = 1'b0;
    strobe(3'd1);
    shift_out(40, got);
    ceq("R3 R11 hold kept data", 64'(got), 64'(p & MASK40));
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule